// File: doc/BRIEF.md
# Memory-Based Interrupt Report Writer

This block sits on the engine side of an interrupt scheme in which interrupt state is delivered through host memory rather than through device registers. Reporting units raise events, each carrying a source index, an engine instance number and a 16-bit event vector. Events are OR-merged into a per-slot pending store. One slot at a time is turned into a report. For each report the block reads an enable mask word from memory and drops the disabled event bits. It then writes one 0xFF marker byte for every surviving bit, then writes a 0xFF flag byte for the source, and only after the last write is acknowledged does it pulse the interrupt line to the host.

All addresses are taken from a programmable page base. Within a page, the status bytes of a source form a 16-byte block at offset `source*16`. The source flag bytes sit from offset 0x400, and the enable mask word is at 0x440. When per-instance paging is selected, instance `n` uses the page at `base + n*4096`. Otherwise every report uses the base page. The host consumes a report by zeroing the bytes. The block only ever writes 0xFF.

Top module: `mbi_report_writer`

## Requirements
- R1: For every event bit that is set and enabled, one byte write of value 0xFF is issued to `page + source*16 + bit`. Within one report these writes go out in ascending bit order.
- R2: After the last status byte of a report, exactly one 0xFF write goes to `page + 0x400 + source`. No status write of that report follows it.
- R3: Each report starts with one read of the 32-bit mask word at `page + 0x440`. An event bit `b` survives only when mask bit `b` is 1.
- R4: If no event bit survives the mask, the report issues no memory write and no interrupt.
- R5: `irq_pulse` is high for exactly one cycle, in the cycle after the acknowledge of the source flag write. It is never high while a read or write request is pending. Read, write and interrupt are mutually exclusive.
- R6: With `cfg_per_inst`=1 the page is `cfg_base + instance*4096`. With `cfg_per_inst`=0 the instance is ignored and the page is `cfg_base`.
- R7: `cfg_err` is high whenever `cfg_base[11:0]` is nonzero. While it is high, no report starts, and pending events are kept until the base is aligned again.
- R8: Events to the same slot are OR-merged while they wait. An event that arrives after a report has captured its slot is kept and reported by a later report. No event is lost.
- R9: `mem_wr_req` and `mask_rd_req` stay high, with a stable address, until the matching acknowledge is seen.
- R10: When several slots are pending, the slot with the lowest index (`instance*NUM_SRC + source`) is reported first.
- R11: After reset there are no requests, no interrupt and no pending events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Page base address, 4 KiB aligned |
| cfg_per_inst | input | 1 | 1: one page per engine instance; 0: all reports use the base page |
| cfg_err | output | 1 | Page base misaligned; reporting paused |
| ev_valid | input | 1 | Event strobe |
| ev_inst | input | INST_W | Engine instance of the event |
| ev_src | input | SRC_W | Source index of the event |
| ev_vec | input | VEC_W | Event bits |
| mask_rd_req | output | 1 | Mask word read request |
| mask_rd_addr | output | ADDR_W | Mask word address |
| mask_rd_data | input | MASK_W | Mask word returned with the acknowledge |
| mask_rd_ack | input | 1 | Read acknowledge |
| mem_wr_req | output | 1 | Byte write request |
| mem_wr_addr | output | ADDR_W | Byte write address |
| mem_wr_data | output | 8 | Byte write value, always 0xFF |
| mem_wr_ack | input | 1 | Write acknowledge |
| irq_pulse | output | 1 | One-cycle interrupt to the host |

## Verification
Some properties are checked on every cycle: the single-cycle interrupt and its placement right after a write acknowledge, exclusivity of read, write and interrupt, requests held stable until acknowledged, no report starting under a misaligned base, and addresses staying inside the report page. The scoreboard covers what needs a whole scenario. This includes the exact address sequence of each report, the mask filtering down to a silent report, and page selection in both paging modes. It also covers lowest-slot-first ordering after a paused period, and OR-merging both before a report and during one.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
   localparam int unsigned PAGE_SHIFT     = 12;
   localparam int unsigned STAT_OFS       = 'h000;
   localparam int unsigned FLAG_OFS       = 'h400;
   localparam int unsigned MASK_OFS       = 'h440;
   localparam int unsigned STAT_STRIDE_SH = 4;
   localparam logic [7:0]  MARK_BYTE      = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_STAT,
      ST_FLAG,
      ST_IRQ
   } wr_state_e;

   typedef enum logic [1:0] {
      AK_STAT,
      AK_FLAG,
      AK_MASK
   } area_e;
endpackage

// File: rtl/mbi_ffs.sv
// Lowest-set-bit finder.
module mbi_ffs #(
   parameter int W  = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mbi_pend_store.sv
// Per-slot pending event bits, OR-merged; a capture clears the slot
// while a same-cycle event to that slot is kept.
module mbi_pend_store #(
   parameter int NUM_SLOT = 128,
   parameter int VEC_W    = 16,
   localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [SLOT_W-1:0]   set_slot,
   input  logic [VEC_W-1:0]    set_vec,
   input  logic                clr_en,
   input  logic [SLOT_W-1:0]   clr_slot,
   input  logic [SLOT_W-1:0]   rd_slot,
   output logic [VEC_W-1:0]    rd_vec,
   output logic [NUM_SLOT-1:0] nz
);
   logic [NUM_SLOT*VEC_W-1:0] flat;

   for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
      logic [VEC_W-1:0] q;
      logic             hit_set;
      logic             hit_clr;
      assign hit_set = set_en && (set_slot == SLOT_W'(g));
      assign hit_clr = clr_en && (clr_slot == SLOT_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit_clr) begin
            q <= hit_set ? set_vec : '0;
         end else if (hit_set) begin
            q <= q | set_vec;
         end
      end
      assign flat[g*VEC_W +: VEC_W] = q;
      assign nz[g] = |q;
   end

   assign rd_vec = flat[32'(rd_slot)*VEC_W +: VEC_W];
endmodule

// File: rtl/mbi_addr_gen.sv
// Address of a status byte, a source flag byte or the mask word within a page.
module mbi_addr_gen
   import mbi_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SRC_W  = 6,
   parameter int BIT_W  = 4
) (
   input  logic [ADDR_W-1:0] page,
   input  logic [SRC_W-1:0]  src,
   input  logic [BIT_W-1:0]  bit_idx,
   input  area_e             area,
   output logic [ADDR_W-1:0] addr
);
   always_comb begin
      case (area)
         AK_FLAG: addr = page + ADDR_W'(FLAG_OFS) + ADDR_W'(src);
         AK_MASK: addr = page + ADDR_W'(MASK_OFS);
         default: addr = page + ADDR_W'(STAT_OFS)
                         + (ADDR_W'(src) << STAT_STRIDE_SH) + ADDR_W'(bit_idx);
      endcase
   end
endmodule

// File: rtl/mbi_report_writer.sv
module mbi_report_writer
   import mbi_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_SRC   = 64,
   parameter int NUM_INST  = 2,
   parameter int VEC_W     = 16,
   parameter int MASK_W    = 32,
   localparam int SRC_W    = $clog2(NUM_SRC),
   localparam int INST_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
   localparam int NUM_SLOT = NUM_SRC * NUM_INST,
   localparam int SLOT_W   = $clog2(NUM_SLOT),
   localparam int BIT_W    = $clog2(VEC_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              cfg_per_inst,
   output logic              cfg_err,
   input  logic              ev_valid,
   input  logic [INST_W-1:0] ev_inst,
   input  logic [SRC_W-1:0]  ev_src,
   input  logic [VEC_W-1:0]  ev_vec,
   output logic              mask_rd_req,
   output logic [ADDR_W-1:0] mask_rd_addr,
   input  logic [MASK_W-1:0] mask_rd_data,
   input  logic              mask_rd_ack,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [7:0]        mem_wr_data,
   input  logic              mem_wr_ack,
   output logic              irq_pulse
);
   // ---------------- elaboration checks ----------------
   if (NUM_SRC < 2 || NUM_SRC > 64 || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_bad_src
      $error("NUM_SRC must be a power of two in 2..64");
   end
   if (NUM_INST < 1 || (NUM_INST & (NUM_INST - 1)) != 0) begin : g_bad_inst
      $error("NUM_INST must be a power of two");
   end
   if (VEC_W < 2 || VEC_W > 16 || (VEC_W & (VEC_W - 1)) != 0) begin : g_bad_vec
      $error("VEC_W must be a power of two in 2..16");
   end
   if (MASK_W < VEC_W) begin : g_bad_mask
      $error("MASK_W must cover VEC_W");
   end
   if (ADDR_W <= PAGE_SHIFT + INST_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the page layout");
   end

   // ---------------- slot mapping ----------------
   logic [SLOT_W-1:0] ev_slot;
   logic [SLOT_W-1:0] sel_slot;
   logic [ADDR_W-1:0] sel_page;
   logic [VEC_W-1:0]  sel_vec;
   logic [NUM_SLOT-1:0] slot_nz;
   logic              any_pend;

   if (NUM_INST > 1) begin : g_multi
      assign ev_slot  = cfg_per_inst ? {ev_inst, ev_src} : SLOT_W'(ev_src);
      assign sel_page = cfg_base + (ADDR_W'(sel_slot[SLOT_W-1:SRC_W]) << PAGE_SHIFT);
   end else begin : g_single
      logic unused_inst;
      assign unused_inst = ^{ev_inst, cfg_per_inst};
      assign ev_slot  = ev_src;
      assign sel_page = cfg_base;
   end

   if (MASK_W > VEC_W) begin : g_mask_hi
      logic unused_mask_hi;
      assign unused_mask_hi = ^mask_rd_data[MASK_W-1:VEC_W];
   end

   assign cfg_err = |cfg_base[PAGE_SHIFT-1:0];

   // ---------------- report state ----------------
   wr_state_e         st_q;
   logic [SRC_W-1:0]  src_q;
   logic [ADDR_W-1:0] page_q;
   logic [VEC_W-1:0]  vec_q;
   logic [VEC_W-1:0]  rem_q;
   logic              start;
   logic [BIT_W-1:0]  bit_idx;
   logic              bit_found_unused;
   logic [VEC_W-1:0]  rem_after;
   logic [VEC_W-1:0]  eff_vec;
   area_e             area;
   logic [ADDR_W-1:0] gen_addr;

   assign start = (st_q == ST_IDLE) && any_pend && !cfg_err;

   mbi_pend_store #(
      .NUM_SLOT (NUM_SLOT),
      .VEC_W    (VEC_W)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (ev_valid),
      .set_slot (ev_slot),
      .set_vec  (ev_vec),
      .clr_en   (start),
      .clr_slot (sel_slot),
      .rd_slot  (sel_slot),
      .rd_vec   (sel_vec),
      .nz       (slot_nz)
   );

   mbi_ffs #(.W(NUM_SLOT)) u_slot_ffs (
      .vec   (slot_nz),
      .idx   (sel_slot),
      .found (any_pend)
   );

   mbi_ffs #(.W(VEC_W)) u_bit_ffs (
      .vec   (rem_q),
      .idx   (bit_idx),
      .found (bit_found_unused)
   );

   assign rem_after = rem_q & ~(VEC_W'(1) << bit_idx);
   assign eff_vec   = vec_q & mask_rd_data[VEC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         src_q  <= '0;
         page_q <= '0;
         vec_q  <= '0;
         rem_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  src_q  <= sel_slot[SRC_W-1:0];
                  page_q <= sel_page;
                  vec_q  <= sel_vec;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mask_rd_ack) begin
                  rem_q <= eff_vec;
                  st_q  <= (eff_vec == '0) ? ST_IDLE : ST_STAT;
               end
            end
            ST_STAT: begin
               if (mem_wr_ack) begin
                  rem_q <= rem_after;
                  if (rem_after == '0) st_q <= ST_FLAG;
               end
            end
            ST_FLAG: begin
               if (mem_wr_ack) st_q <= ST_IRQ;
            end
            ST_IRQ:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_FLAG:  area = AK_FLAG;
         ST_FETCH: area = AK_MASK;
         default:  area = AK_STAT;
      endcase
   end

   mbi_addr_gen #(
      .ADDR_W (ADDR_W),
      .SRC_W  (SRC_W),
      .BIT_W  (BIT_W)
   ) u_addr (
      .page    (page_q),
      .src     (src_q),
      .bit_idx (bit_idx),
      .area    (area),
      .addr    (gen_addr)
   );

   assign mask_rd_req  = (st_q == ST_FETCH);
   assign mask_rd_addr = gen_addr;
   assign mem_wr_req   = (st_q == ST_STAT) || (st_q == ST_FLAG);
   assign mem_wr_addr  = gen_addr;
   assign mem_wr_data  = MARK_BYTE;
   assign irq_pulse    = (st_q == ST_IRQ);
endmodule

// File: rtl/mbi_report_writer_chk.sv
module mbi_report_writer_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_err,
   input logic              mask_rd_req,
   input logic              mask_rd_ack,
   input logic [ADDR_W-1:0] mask_rd_addr,
   input logic              mem_wr_req,
   input logic              mem_wr_ack,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic              irq_pulse
);
   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse)
      else $error("irq_pulse longer than one cycle");

   assert_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(mem_wr_req && mem_wr_ack))
      else $error("irq_pulse without a preceding write acknowledge");

   assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_wr_req, mask_rd_req, irq_pulse}))
      else $error("read, write and interrupt overlap");

   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)))
      else $error("write request dropped or changed before acknowledge");

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd_req && !mask_rd_ack) |=> (mask_rd_req && $stable(mask_rd_addr)))
      else $error("read request dropped or changed before acknowledge");

   assert_no_start_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mask_rd_req) |-> $past(!cfg_err))
      else $error("report started under a misaligned base");

   assert_wr_in_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> (mem_wr_addr[11:0] < 12'h440))
      else $error("write outside status and flag areas");

   assert_rd_mask_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_rd_req |-> (mask_rd_addr[11:0] == 12'h440))
      else $error("mask read at wrong offset");
endmodule

bind mbi_report_writer mbi_report_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_err      (cfg_err),
   .mask_rd_req  (mask_rd_req),
   .mask_rd_ack  (mask_rd_ack),
   .mask_rd_addr (mask_rd_addr),
   .mem_wr_req   (mem_wr_req),
   .mem_wr_ack   (mem_wr_ack),
   .mem_wr_addr  (mem_wr_addr),
   .irq_pulse    (irq_pulse)
);

// File: tb/tb_mbi_report_writer.sv
module tb_mbi_report_writer;
   localparam int ADDR_W = 32;
   localparam int NUM_SRC = 64;
   localparam int NUM_INST = 2;
   localparam int VEC_W = 16;
   localparam int MASK_W = 32;
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_IRQ = 2'd2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic [31:0]       cfg_base;
   logic              cfg_per_inst;
   logic              cfg_err;
   logic              ev_valid;
   logic [0:0]        ev_inst;
   logic [5:0]        ev_src;
   logic [15:0]       ev_vec;
   logic              rd_req;
   logic [31:0]       rd_addr;
   logic [31:0]       rd_data = '0;
   logic              rd_ack = 1'b0;
   logic              wr_req;
   logic [31:0]       wr_addr;
   logic [7:0]        wr_data;
   logic              wr_ack = 1'b0;
   logic              irq;

   mbi_report_writer #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_INST(NUM_INST),
      .VEC_W(VEC_W), .MASK_W(MASK_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_per_inst(cfg_per_inst),
      .cfg_err(cfg_err), .ev_valid(ev_valid), .ev_inst(ev_inst), .ev_src(ev_src),
      .ev_vec(ev_vec), .mask_rd_req(rd_req), .mask_rd_addr(rd_addr),
      .mask_rd_data(rd_data), .mask_rd_ack(rd_ack), .mem_wr_req(wr_req),
      .mem_wr_addr(wr_addr), .mem_wr_data(wr_data), .mem_wr_ack(wr_ack),
      .irq_pulse(irq)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [31:0] addr;
      logic [7:0]  req;
   } item_t;

   item_t       exp_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] mask_word = 32'hFFFF_FFFF;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic take(logic [1:0] kind, logic [31:0] addr, logic [7:0] data);
      item_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4", $sformatf("unexpected transaction of kind %0d", kind), addr, 32'h0);
      end else begin
         e = exp_q.pop_front();
         chk(kind == e.kind && addr == e.addr, $sformatf("R%0d", e.req),
             $sformatf("transaction kind %0d (expected kind %0d)", kind, e.kind), addr, e.addr);
         if (kind == K_WR) chk(data == 8'hFF, "R1", "written byte value", 32'(data), 32'hFF);
      end
   endtask

   // Driver side: expected transactions of one report.
   task automatic push_report(logic [31:0] page, int src, logic [15:0] vec,
                              logic [31:0] mask, int rtag);
      logic [15:0] eff;
      eff = vec & mask[15:0];
      exp_q.push_back('{K_RD, page + 32'h440, 8'(rtag)});           // R3
      for (int b = 0; b < 16; b++) begin
         if (eff[b]) exp_q.push_back('{K_WR, page + 32'(src * 16) + 32'(b), 8'd1}); // R1
      end
      if (eff != 16'h0) begin
         exp_q.push_back('{K_WR, page + 32'h400 + 32'(src), 8'd2});  // R2
         exp_q.push_back('{K_IRQ, 32'h0, 8'd5});                     // R5
      end
   endtask

   task automatic send(int inst, int src, logic [15:0] vec);
      ev_valid = 1'b1;
      ev_inst  = 1'(inst);
      ev_src   = 6'(src);
      ev_vec   = vec;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   // Monitor and memory model: acknowledges with varying delay, pops the scoreboard.
   int          wdly = 0;
   int          dpat = 0;
   bit          w_hold = 1'b0;
   logic [31:0] w_hold_addr = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         wr_ack = 1'b0;
         rd_ack = 1'b0;
         w_hold = 1'b0;
      end else begin
         if (wr_ack) begin
            wr_ack = 1'b0;
            w_hold = 1'b0;
         end else if (wr_req) begin
            if (w_hold) chk(wr_addr == w_hold_addr, "R9", "write address held until ack",
                            wr_addr, w_hold_addr);
            if (wdly > 0) begin
               wdly--;
               w_hold      = 1'b1;
               w_hold_addr = wr_addr;
            end else begin
               take(K_WR, wr_addr, wr_data);
               wr_ack = 1'b1;
               dpat   = (dpat + 1) % 3;
               wdly   = dpat;
            end
         end
         if (rd_ack) begin
            rd_ack = 1'b0;
         end else if (rd_req) begin
            take(K_RD, rd_addr, 8'h0);
            rd_data = mask_word;
            rd_ack  = 1'b1;
         end
         if (irq) take(K_IRQ, 32'h0, 8'h0);
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n        = 1'b0;
      cfg_base     = 32'h0002_0000;
      cfg_per_inst = 1'b1;
      ev_valid     = 1'b0;
      ev_inst      = '0;
      ev_src       = '0;
      ev_vec       = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: quiet after reset
      chk(!wr_req && !rd_req && !irq, "R11", "no activity after reset",
          32'({wr_req, rd_req, irq}), 32'h0);
      chk(cfg_err == 1'b0, "R7", "aligned base flags no error", 32'(cfg_err), 32'h0);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && !wr_req, "R11", "no pending report after reset",
          32'(wr_req), 32'h0);

      // R1 R2 R3: instance 1 page, several bits, full mask
      mask_word = 32'hFFFF_FFFF;
      push_report(32'h0002_1000, 3, 16'h8005, mask_word, 3);
      send(1, 3, 16'h8005);
      drain();

      // R3: mask filters bits
      mask_word = 32'h0000_0011;
      push_report(32'h0002_0000, 10, 16'h00F1, mask_word, 3);
      send(0, 10, 16'h00F1);
      drain();

      // R4: every bit masked off -> read only
      mask_word = 32'h0000_0001;
      push_report(32'h0002_0000, 1, 16'h0002, mask_word, 4);
      send(0, 1, 16'h0002);
      drain();
      chk(!wr_req && !irq, "R4", "silent report leaves no write or irq",
          32'({wr_req, irq}), 32'h0);

      // R6 shared mode: instance ignored, base page used
      cfg_per_inst = 1'b0;
      push_report(32'h0002_0000, 5, 16'h0001, mask_word, 6);
      send(1, 5, 16'h0001);
      drain();
      cfg_per_inst = 1'b1;

      // R7 misaligned base pauses; R8 merge while waiting; R10 lowest slot first
      mask_word = 32'hFFFF_FFFF;
      cfg_base  = 32'h0002_0010;
      @(negedge clk);
      chk(cfg_err == 1'b1, "R7", "misaligned base flagged", 32'(cfg_err), 32'h1);
      send(1, 9, 16'h0002);
      send(1, 9, 16'h0008);
      send(0, 2, 16'h0004);
      repeat (20) @(negedge clk);
      chk(!rd_req && !wr_req && !irq, "R7", "no report under misaligned base",
          32'({rd_req, wr_req, irq}), 32'h0);
      push_report(32'h0002_0000, 2, 16'h0004, mask_word, 10);
      push_report(32'h0002_1000, 9, 16'h000A, mask_word, 8);
      cfg_base = 32'h0002_0000;
      @(negedge clk);
      chk(cfg_err == 1'b0, "R7", "error clears with aligned base", 32'(cfg_err), 32'h0);
      drain();

      // R8: event to the same slot during a report goes to a later report
      push_report(32'h0002_0000, 7, 16'h0003, mask_word, 3);
      send(0, 7, 16'h0003);
      while (!rd_req) @(negedge clk);
      push_report(32'h0002_0000, 7, 16'h0101, mask_word, 8);
      send(0, 7, 16'h0101);
      drain();

      chk(exp_q.size() == 0, "R5", "all expected transactions seen",
          32'(exp_q.size()), 32'h0);
      summary();
      $finish;
   end
endmodule